// File: doc/BRIEF.md
# AXI Handshake Stall Monitor

This block watches the valid/ready handshake on the five channels of an AXI port and flags any channel whose valid stays high too long without a ready in reply. Each channel has its own timer. A handshake that completes on the edge where valid is first seen starts no timing. Otherwise the timer counts the rising edges on which valid is high and ready is low. When that count reaches the limit, the channel's error flag is raised. The timer clears when the handshake completes, and also when valid is withdrawn before ready comes back.

The monitor sits beside a bus in a simulation or emulation build and only observes. Because each channel is timed on its own, a hang is reported against the exact channel whose ready never arrived, not as a general loss of bus activity. Error flags stay set until reset. A combined flag and the index of the first failing channel give a quick summary.

Top module: `axi_stall_monitor`

## Requirements
- R1: While reset is held low at a rising edge, and after it is released, every channel error flag, the combined error and the first-failure index read zero until a stall is detected.
- R2: A channel whose valid and ready are both high at the same sampled edge is not timed; back-to-back completed handshakes never raise an error.
- R3: A channel's error flag goes high right after the STALL_LIMIT-th consecutive edge that samples valid high with ready low; after STALL_LIMIT-1 such edges it is still low.
- R4: An edge that samples valid low clears that channel's stall count, so a later stall is counted from one again.
- R5: An edge that samples valid and ready both high ends the wait and clears the stall count; the next stall is counted afresh.
- R6: A channel error flag stays high until reset, whatever the channel's valid and ready do afterwards.
- R7: Channels are independent: a stall on one channel never sets another channel's flag.
- R8: The combined error output is high exactly when at least one channel error flag is high.
- R9: The first-failure index is captured on the edge that raises the first error since reset, and later errors do not change it. If several channels fail on that same edge, the lowest index is captured.
- R10: Channel bit positions are fixed: bit 0 read address, bit 1 write address, bit 2 write data, bit 3 read data, bit 4 write response. The first-failure index uses the same numbering.
- R11: Ready high while valid is low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared with the observed bus |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_valid | input | NUM_CH | Valid bit of each channel, numbered as in R10 |
| ch_ready | input | NUM_CH | Ready bit of each channel, numbered as in R10 |
| ch_error | output | NUM_CH | Sticky per-channel stall error flags |
| any_error | output | 1 | OR of all channel error flags |
| first_fail_idx | output | IDX_W | Index of the first channel to fail since reset |

## Verification
On every cycle the assertions check that each stall counter stays at or below the limit and is cleared after a completed handshake or a withdrawn valid. They also check that an error flag only rises after the limit-th stalled edge, that flags never fall outside reset, and that the captured index is stable and points at a failed channel. The exact cycle on which a flag rises, the absence of an error one cycle short of the limit, and the tie-break between channels that fail together can only be shown by the bench. The same holds for the way the channels stay isolated under mixed random traffic.

// File: rtl/axi_stall_pkg.sv
// Package: shared constants and channel numbering for the stall monitor.
// Assumes: five channels, numbered in the fixed order given below.
package axi_stall_pkg;

    // Fixed channel numbering; the first-failure index uses these values.
    typedef enum logic [2:0] {
        CH_RD_ADDR = 3'd0,
        CH_WR_ADDR = 3'd1,
        CH_WR_DATA = 3'd2,
        CH_RD_DATA = 3'd3,
        CH_WR_RESP = 3'd4
    } axi_chan_e;

    localparam int unsigned AXI_CHANNELS    = 5;
    localparam int unsigned DEF_CLK_MHZ     = 100;
    localparam int unsigned DEF_TIMEOUT_NS  = 10000;

    // Converts a timeout in nanoseconds into a whole number of clock cycles.
    function automatic int unsigned ns_to_cycles(input int unsigned clk_mhz,
                                                 input int unsigned t_ns);
        return (clk_mhz * t_ns) / 1000;
    endfunction

endpackage

// File: rtl/stall_channel_timer.sv
// Module: stall_channel_timer
// Times one channel's pending handshake (valid high, ready low) in sampled
// edges and raises a sticky error once the count reaches STALL_LIMIT.
// Assumes: STALL_LIMIT >= 2; valid/ready are synchronous to clk.
module stall_channel_timer #(
    parameter int unsigned STALL_LIMIT = 1000,
    localparam int unsigned CNT_W      = $clog2(STALL_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic ready,
    output logic err_q,
    output logic err_rise
);

    localparam logic [CNT_W-1:0] LIMIT_C    = CNT_W'(STALL_LIMIT);
    localparam logic [CNT_W-1:0] LIMIT_M1_C = CNT_W'(STALL_LIMIT - 1);

    logic [CNT_W-1:0] stall_cnt;
    logic             pending;

    // Valid sampled high with no ready in reply: the handshake is still waiting.
    assign pending  = valid & ~ready;

    // Flags the edge on which this channel's error will first be set.
    assign err_rise = pending & (stall_cnt == LIMIT_M1_C) & ~err_q;

    // Counts consecutive stalled edges; clears on completion or withdrawn valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_cnt <= '0;
        end else if (pending) begin
            if (stall_cnt != LIMIT_C) begin
                stall_cnt <= stall_cnt + 1'b1;
            end
        end else begin
            stall_cnt <= '0;
        end
    end

    // Holds the error flag from the limit-th stalled edge until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_rise) begin
            err_q <= 1'b1;
        end
    end

    // The stall count saturates at the limit (R3).
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall_cnt <= LIMIT_C);

    // A completed handshake leaves the count cleared (R5, R2).
    assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> (stall_cnt == '0));

    // A withdrawn valid leaves the count cleared (R4).
    assert_drop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (stall_cnt == '0));

    // The flag only rises after the limit-th stalled edge (R3).
    assert_rise_at_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(pending && (stall_cnt == LIMIT_M1_C)));

    // Once set, the flag stays set outside reset (R6).
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: rtl/first_fail_latch.sv
// Module: first_fail_latch
// Captures the index of the first channel to fail since reset, picking the
// lowest index when several channels fail on the same edge.
// Assumes: err_rise pulses are aligned with the edge that sets err_vec.
module first_fail_latch #(
    parameter int unsigned NUM_CH = 5,
    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] err_vec,
    input  logic [NUM_CH-1:0] err_rise,
    output logic              any_err,
    output logic [IDX_W-1:0]  first_idx
);

    logic [IDX_W-1:0] lowest_idx;

    // Combined error is the OR of every channel flag.
    assign any_err = |err_vec;

    // Priority encoder: lowest-numbered channel among those failing now.
    always_comb begin
        lowest_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (err_rise[i]) begin
                lowest_idx = IDX_W'(i);
            end
        end
    end

    // Latches the index only on the edge that raises the first error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_idx <= '0;
        end else if (!any_err && (|err_rise)) begin
            first_idx <= lowest_idx;
        end
    end

    // The captured index never moves once an error is present (R9).
    assert_idx_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        any_err |=> $stable(first_idx));

    // The captured index always names a channel that has failed (R9).
    assert_idx_points_R9: assert property (@(posedge clk) disable iff (!rst_n)
        any_err |-> err_vec[first_idx]);

endmodule

// File: rtl/axi_stall_monitor.sv
// Module: axi_stall_monitor (top)
// One stall timer per AXI channel plus a first-failure latch. Passive: it
// only observes valid/ready and reports stuck handshakes.
// Assumes: channel bits numbered as in axi_stall_pkg::axi_chan_e.
module axi_stall_monitor
    import axi_stall_pkg::*;
#(
    parameter int unsigned NUM_CH      = AXI_CHANNELS,
    parameter int unsigned CLK_MHZ     = DEF_CLK_MHZ,
    parameter int unsigned TIMEOUT_NS  = DEF_TIMEOUT_NS,
    parameter int unsigned STALL_LIMIT = ns_to_cycles(CLK_MHZ, TIMEOUT_NS),
    localparam int unsigned IDX_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_valid,
    input  logic [NUM_CH-1:0] ch_ready,
    output logic [NUM_CH-1:0] ch_error,
    output logic              any_error,
    output logic [IDX_W-1:0]  first_fail_idx
);

    logic [NUM_CH-1:0] rise_vec;

    // One independent timer per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        stall_channel_timer #(
            .STALL_LIMIT (STALL_LIMIT)
        ) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .valid    (ch_valid[g]),
            .ready    (ch_ready[g]),
            .err_q    (ch_error[g]),
            .err_rise (rise_vec[g])
        );
    end

    first_fail_latch #(
        .NUM_CH (NUM_CH)
    ) u_first (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_vec   (ch_error),
        .err_rise  (rise_vec),
        .any_err   (any_error),
        .first_idx (first_fail_idx)
    );

    // A flag can only appear on a channel that was stalled on the prior edge (R7).
    assert_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_error & ~$past(ch_error)) == (ch_error & ~$past(ch_error)
                                          & $past(ch_valid & ~ch_ready)));

endmodule

// File: tb/axi_stall_monitor_bench.sv
// Bench: directed corner cases plus seeded random traffic, checked against a
// model of the requirements kept in bench arrays.
module axi_stall_monitor_bench;

    localparam int NCH = 5;
    localparam int LIM = 12;
    localparam int IW  = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] ch_valid;
    logic [NCH-1:0] ch_ready;
    logic [NCH-1:0] ch_error;
    logic           any_error;
    logic [IW-1:0]  first_fail_idx;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // Expected state derived from the requirements.
    int             m_cnt [NCH];
    logic [NCH-1:0] m_err;
    logic [IW-1:0]  m_idx;

    always #5 clk = ~clk;

    axi_stall_monitor #(
        .NUM_CH      (NCH),
        .STALL_LIMIT (LIM)
    ) u_axi_stall_monitor (
        .clk            (clk),
        .rst_n          (rst_n),
        .ch_valid       (ch_valid),
        .ch_ready       (ch_ready),
        .ch_error       (ch_error),
        .any_error      (any_error),
        .first_fail_idx (first_fail_idx)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
        m_err = '0;
        m_idx = '0;
    endtask

    // Expected effect of one sampled edge (R2-R5, R9).
    task automatic model_edge(input logic [NCH-1:0] v, input logic [NCH-1:0] r);
        logic [NCH-1:0] newly;
        newly = '0;
        for (int c = 0; c < NCH; c++) begin
            if (v[c] && !r[c]) begin
                if (m_cnt[c] < LIM) m_cnt[c]++;
                if (m_cnt[c] == LIM && !m_err[c]) newly[c] = 1'b1;
            end else begin
                m_cnt[c] = 0;
            end
        end
        if (m_err == '0 && newly != '0) begin
            for (int c = NCH - 1; c >= 0; c--) if (newly[c]) m_idx = IW'(c);
        end
        m_err = m_err | newly;
    endtask

    // Drive at a falling edge, let one rising edge sample, return at the next fall.
    task automatic tick(input logic [NCH-1:0] v, input logic [NCH-1:0] r);
        ch_valid = v;
        ch_ready = r;
        @(posedge clk);
        if (rst_n) model_edge(v, r); else model_reset();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick('0, '0);
        tick('0, '0);
        rst_n = 1'b1;
    endtask

    task automatic compare_all(input string req);
        chk({req, " ch_error"}, int'(ch_error), int'(m_err));
        chk({req, " any_error"}, int'(any_error), int'(m_err != '0));
        chk({req, " first_fail_idx"}, int'(first_fail_idx), int'(m_idx));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        for (int n = 0; n < 150000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        int rp [NCH];
        logic [NCH-1:0] v, r;
        seed = $urandom(32'h5eed_1234);
        ch_valid = '0;
        ch_ready = '0;
        rst_n    = 1'b0;
        model_reset();
        @(negedge clk);
        do_reset();

        // R1: all outputs clear after reset.
        chk("R1 ch_error", int'(ch_error), 0);
        chk("R1 any_error", int'(any_error), 0);
        chk("R1 first_fail_idx", int'(first_fail_idx), 0);

        // R3/R5: stall one short of the limit on read address, then complete.
        for (int k = 0; k < LIM - 1; k++) tick(5'b00001, 5'b00000);
        chk("R3 short stall no error", int'(ch_error), 0);
        tick(5'b00001, 5'b00001);
        for (int k = 0; k < LIM - 1; k++) tick(5'b00001, 5'b00000);
        chk("R5 fresh count after handshake", int'(ch_error), 0);
        tick(5'b00000, 5'b00000);

        // R4: withdrawn valid restarts the write-address count.
        for (int k = 0; k < LIM - 2; k++) tick(5'b00010, 5'b00000);
        tick(5'b00000, 5'b00000);
        for (int k = 0; k < LIM - 2; k++) tick(5'b00010, 5'b00000);
        chk("R4 drop restarts count", int'(ch_error), 0);
        tick(5'b00000, 5'b00000);

        // R11 and R2: ready alone, then continuous completed handshakes.
        for (int k = 0; k < 3 * LIM; k++) tick(5'b00000, 5'b11111);
        chk("R11 ready without valid", int'(ch_error), 0);
        chk("R11 any_error", int'(any_error), 0);
        for (int k = 0; k < 3 * LIM; k++) tick(5'b00100, 5'b00100);
        chk("R2 back-to-back handshakes", int'(ch_error), 0);
        compare_all("R2");

        // R3/R7/R8/R9/R10: read-data channel (bit 3) stalls to the limit.
        for (int k = 0; k < LIM - 1; k++) tick(5'b01000, 5'b00000);
        chk("R3 one edge before limit", int'(ch_error), 0);
        tick(5'b01000, 5'b00000);
        chk("R3 flag at limit", int'(ch_error[3]), 1);
        chk("R7 other channels clear", int'(ch_error & 5'b10111), 0);
        chk("R8 combined error", int'(any_error), 1);
        chk("R10 read data index", int'(first_fail_idx), 3);
        tick(5'b01000, 5'b01000);
        for (int k = 0; k < 4; k++) tick(5'b00000, 5'b00000);
        chk("R6 flag sticky", int'(ch_error[3]), 1);
        for (int k = 0; k < LIM; k++) tick(5'b00001, 5'b00000);
        chk("R7 read address flagged", int'(ch_error), 9);
        chk("R9 index kept", int'(first_fail_idx), 3);
        compare_all("R9");

        // R9 tie: write response and write address fail on the same edge.
        do_reset();
        model_reset();
        chk("R1 flags cleared by reset", int'(ch_error), 0);
        for (int k = 0; k < LIM; k++) tick(5'b10010, 5'b00000);
        chk("R9 tie flags", int'(ch_error), 5'b10010);
        chk("R9 lowest index on tie", int'(first_fail_idx), 1);

        // Random traffic, mixed ready probabilities, periodic reset.
        for (int blk = 0; blk < 40; blk++) begin
            if (blk % 8 == 0) begin
                do_reset();
                model_reset();
            end
            for (int c = 0; c < NCH; c++) begin
                case ($urandom % 3)
                    0: rp[c] = 0;
                    1: rp[c] = 8;
                    default: rp[c] = 50;
                endcase
            end
            for (int k = 0; k < 64; k++) begin
                for (int c = 0; c < NCH; c++) begin
                    v[c] = (($urandom % 100) < 85);
                    r[c] = (($urandom % 100) < rp[c]);
                end
                tick(v, r);
                compare_all("R3 R4 R5 R7 R8 R9 random");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule